// File: doc/BRIEF.md
# Bus Parity Error Reporter

This block watches a 32-bit multiplexed address/data bus with four active-low byte-enable lines and one parity line. It checks even parity on address and data phases and reports mismatches on two active-low error outputs: a data-error line and a system-error line. It also produces the outgoing parity bit for phases the host side drives.

A 16-bit command word sets how errors are reported. Only two bits of it can be written: a response enable and a system-error enable. All other bits read as zero. The enables are layered:
- A data error reaches the data-error line only when response is enabled.
- An address error reaches the system-error line only when both enables are set.
- A data error received as target also reaches the system-error line, but only if a separate write-data enable input is high as well.

A detected-error flag records every mismatch, whatever the enables are set to. Writing a one to a clear input resets it.

The surrounding bus logic tells the block, each cycle, whether an address phase or a data phase is being received and whether the block acts as target. The parity for that phase arrives one clock later. An error report appears one clock after that.

Top module: `pcipar_err_report`

## Requirements
- R1: Only bit 8 (system-error enable) and bit 6 (response enable) of `cmd_rdata` hold written values. Every other bit of the 16-bit word reads as 0 whatever is written. Both enables are 0 after reset.
- R2: In the cycle after a clock edge, `par_out` equals the XOR of the 36 bits of `ad` and `cbe_n` sampled at that edge. `par_oe` equals `drive_en` sampled at that edge. Generation runs whatever the enables are set to.
- R3: A phase flagged at edge t is checked against `par_in` sampled at edge t+1. A mismatch exists when `par_in` differs from the XOR of that phase's `ad` and `cbe_n`.
- R4: A data-phase mismatch drives `perr_n` low for the one cycle after edge t+1 if the response enable is 1 at edge t+1. This holds in both master and target roles. With the response enable at 0, `perr_n` stays high.
- R5: An address-phase mismatch drives `serr_n` low for the one cycle after edge t+1 only if both enables are 1. `perr_n` is not driven for address errors.
- R6: A data-phase mismatch with `as_target`=1 drives `serr_n` low as well, but only if both enables and `wdpe_en` are 1. A data mismatch with `as_target`=0 never drives `serr_n`.
- R7: `det_flag` is set by any mismatch regardless of the enables. It is cleared by `det_clr`=1 at an edge with no mismatch. A mismatch at the same edge wins over the clear.
- R8: Synchronous reset sets `perr_n` and `serr_n` to 1 and `par_oe` and `det_flag` to 0, and discards any phase waiting for its parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word write value |
| cmd_rdata | output | 16 | Command word read value |
| wdpe_en | input | 1 | Extra enable for target data errors on system-error line |
| det_clr | input | 1 | Write-one-to-clear for the detected-error flag |
| det_flag | output | 1 | Detected parity error flag |
| ad | input | 32 | Address/data bus sample |
| cbe_n | input | 4 | Command/byte-enable sample, active low |
| par_in | input | 1 | Parity line sample, one clock behind its phase |
| drive_en | input | 1 | This cycle's bus value is driven by the host side |
| addr_vld | input | 1 | An address phase is received this cycle |
| data_vld | input | 1 | A data phase is received this cycle |
| as_target | input | 1 | The block acts as target for this phase |
| par_out | output | 1 | Generated even parity |
| par_oe | output | 1 | Parity drive enable |
| perr_n | output | 1 | Data parity error, active low |
| serr_n | output | 1 | System error, active low |

## Verification
The assertions assume that `addr_vld` and `data_vld` are never high in the same cycle. They also assume that a phase's parity is presented in the cycle right after it, even when another phase follows. The stimulus picks at most one phase kind per cycle. It computes `par_in` from the previous cycle's bus value and flips it on purpose to inject errors. The enables and `wdpe_en` are changed freely between phases, so every gating combination meets both address and data mismatches in both roles.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;
    localparam int AD_W    = 32;
    localparam int BE_W    = 4;
    localparam int CMD_W   = 16;
    localparam int SERR_EN_BIT = 8;
    localparam int RESP_EN_BIT = 6;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e kind;
        logic   tgt;
        logic   expect_par;
    } phase_rec_t;

    typedef struct packed {
        logic   hit;
        phase_e kind;
        logic   tgt;
    } mismatch_t;

    typedef struct packed {
        logic serr_en;
        logic resp_en;
    } cmd_en_t;

    function automatic logic even_par(input logic [AD_W-1:0] a, input logic [BE_W-1:0] b);
        return ^{a, b};
    endfunction
endpackage

// File: rtl/pcipar_cmd_reg.sv
module pcipar_cmd_reg
    import pcipar_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output cmd_en_t      en
);
    cmd_en_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (we) begin
            en_q.serr_en <= wdata[SERR_EN_BIT];
            en_q.resp_en <= wdata[RESP_EN_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[SERR_EN_BIT] = en_q.serr_en;
        rdata[RESP_EN_BIT] = en_q.resp_en;
    end

    assign en = en_q;
endmodule

// File: rtl/pcipar_gen.sv
module pcipar_gen
    import pcipar_pkg::*;
#(
    parameter int AW = AD_W,
    parameter int BW = BE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ad,
    input  logic [BW-1:0] cbe_n,
    input  logic          drive_en,
    output logic          par_out,
    output logic          par_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= ^{ad, cbe_n};
            par_oe  <= drive_en;
        end
    end
endmodule

// File: rtl/pcipar_check.sv
module pcipar_check
    import pcipar_pkg::*;
#(
    parameter int AW = AD_W,
    parameter int BW = BE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ad,
    input  logic [BW-1:0] cbe_n,
    input  logic          addr_vld,
    input  logic          data_vld,
    input  logic          as_target,
    input  logic          par_in,
    output mismatch_t     mis
);
    phase_rec_t held_q;
    phase_e     kind_now;

    always_comb begin
        if (addr_vld)      kind_now = PH_ADDR;
        else if (data_vld) kind_now = PH_DATA;
        else               kind_now = PH_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '{kind: PH_NONE, tgt: 1'b0, expect_par: 1'b0};
        end else begin
            held_q.kind       <= kind_now;
            held_q.tgt        <= as_target;
            held_q.expect_par <= ^{ad, cbe_n};
        end
    end

    always_comb begin
        mis.kind = held_q.kind;
        mis.tgt  = held_q.tgt;
        mis.hit  = (held_q.kind != PH_NONE) && (par_in != held_q.expect_par);
    end
endmodule

// File: rtl/pcipar_err_report.sv
module pcipar_err_report
    import pcipar_pkg::*;
#(
    parameter int AW = AD_W,
    parameter int BW = BE_W,
    parameter int CW = CMD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [CW-1:0] cmd_wdata,
    output logic [CW-1:0] cmd_rdata,
    input  logic          wdpe_en,
    input  logic          det_clr,
    output logic          det_flag,
    input  logic [AW-1:0] ad,
    input  logic [BW-1:0] cbe_n,
    input  logic          par_in,
    input  logic          drive_en,
    input  logic          addr_vld,
    input  logic          data_vld,
    input  logic          as_target,
    output logic          par_out,
    output logic          par_oe,
    output logic          perr_n,
    output logic          serr_n
);
    cmd_en_t   en;
    mismatch_t mis;
    logic      perr_fire;
    logic      serr_fire;

    pcipar_cmd_reg #(.W(CW)) u_cmd (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd_we),
        .wdata (cmd_wdata),
        .rdata (cmd_rdata),
        .en    (en)
    );

    pcipar_gen #(.AW(AW), .BW(BW)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .ad       (ad),
        .cbe_n    (cbe_n),
        .drive_en (drive_en),
        .par_out  (par_out),
        .par_oe   (par_oe)
    );

    pcipar_check #(.AW(AW), .BW(BW)) u_chk_pipe (
        .clk       (clk),
        .rst       (rst),
        .ad        (ad),
        .cbe_n     (cbe_n),
        .addr_vld  (addr_vld),
        .data_vld  (data_vld),
        .as_target (as_target),
        .par_in    (par_in),
        .mis       (mis)
    );

    always_comb begin
        perr_fire = mis.hit && (mis.kind == PH_DATA) && en.resp_en;
        serr_fire = 1'b0;
        if (mis.hit && en.resp_en && en.serr_en) begin
            if (mis.kind == PH_ADDR)
                serr_fire = 1'b1;
            else if (mis.kind == PH_DATA && mis.tgt && wdpe_en)
                serr_fire = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_n   <= 1'b1;
            serr_n   <= 1'b1;
            det_flag <= 1'b0;
        end else begin
            perr_n <= ~perr_fire;
            serr_n <= ~serr_fire;
            if (mis.hit)
                det_flag <= 1'b1;
            else if (det_clr)
                det_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pcipar_err_report_chk.sv
module pcipar_err_report_chk #(
    parameter int AW = 32,
    parameter int BW = 4,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cmd_rdata,
    input logic          det_flag,
    input logic [AW-1:0] ad,
    input logic [BW-1:0] cbe_n,
    input logic          drive_en,
    input logic          par_out,
    input logic          par_oe,
    input logic          perr_n,
    input logic          serr_n
);
    localparam logic [CW-1:0] WRITABLE = CW'(16'h0140);

    a_r1_fixed_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdata & ~WRITABLE) == '0);

    a_r2_par_gen: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (par_out == ^{$past(ad), $past(cbe_n)} && par_oe == $past(drive_en)));

    a_r4_perr_gated: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(cmd_rdata[6]));

    a_r5_serr_gated: assert property (@(posedge clk) disable iff (rst)
        !serr_n |-> ($past(cmd_rdata[6]) && $past(cmd_rdata[8])));

    a_r7_flag_follows: assert property (@(posedge clk) disable iff (rst)
        (!perr_n || !serr_n) |-> det_flag);

    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (perr_n && serr_n && !det_flag && !par_oe));
endmodule

bind pcipar_err_report pcipar_err_report_chk #(.AW(AW), .BW(BW), .CW(CW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .cmd_rdata (cmd_rdata),
    .det_flag  (det_flag),
    .ad        (ad),
    .cbe_n     (cbe_n),
    .drive_en  (drive_en),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .perr_n    (perr_n),
    .serr_n    (serr_n)
);

// File: tb/sim_pcipar_err_report.sv
module sim_pcipar_err_report;
    localparam int PERIOD = 10;
    localparam int LIMIT  = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cmd_rdata;
    logic        wdpe_en = 1'b0;
    logic        det_clr = 1'b0;
    logic        det_flag;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        par_in = 1'b0;
    logic        drive_en = 1'b0;
    logic        addr_vld = 1'b0;
    logic        data_vld = 1'b0;
    logic        as_target = 1'b0;
    logic        par_out, par_oe, perr_n, serr_n;

    int vectors = 0;
    int bad = 0;
    bit done = 0;

    pcipar_err_report u0 (.*);

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference: 0 none, 1 address, 2 data
    int m_kind = 0;
    bit m_tgt = 0, m_exp = 0;
    bit m_serr = 0, m_resp = 0;
    bit e_perr_n = 1, e_serr_n = 1, e_det = 0, e_pout = 0, e_poe = 0;

    function automatic bit xor36(input logic [31:0] a, input logic [3:0] b);
        bit r = 0;
        for (int i = 0; i < 32; i++) r ^= a[i];
        for (int i = 0; i < 4; i++) r ^= b[i];
        return r;
    endfunction

    always @(posedge clk) begin
        bit mis;
        if (rst) begin
            m_kind = 0; m_tgt = 0; m_exp = 0; m_serr = 0; m_resp = 0;
            e_perr_n = 1; e_serr_n = 1; e_det = 0; e_pout = 0; e_poe = 0;
        end else begin
            mis = (m_kind != 0) && (par_in != m_exp);
            e_perr_n = !(mis && m_kind == 2 && m_resp);
            e_serr_n = !(mis && m_resp && m_serr &&
                         (m_kind == 1 || (m_kind == 2 && m_tgt && wdpe_en)));
            if (mis) e_det = 1; else if (det_clr) e_det = 0;
            e_pout = xor36(ad, cbe_n);
            e_poe  = drive_en;
            m_kind = addr_vld ? 1 : (data_vld ? 2 : 0);
            m_tgt  = as_target;
            m_exp  = xor36(ad, cbe_n);
            if (cmd_we) begin
                m_serr = cmd_wdata[8];
                m_resp = cmd_wdata[6];
            end
        end
    end

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        vectors++;
        cmp("R1 cmd_rdata", 32'(cmd_rdata), {16'h0, 7'h0, m_serr, 1'b0, m_resp, 6'h0});
        cmp("R2 par_out", 32'(par_out), 32'(e_pout));
        cmp("R2 par_oe", 32'(par_oe), 32'(e_poe));
        cmp("R3 R4 perr_n", 32'(perr_n), 32'(e_perr_n));
        cmp("R5 R6 serr_n", 32'(serr_n), 32'(e_serr_n));
        cmp("R7 det_flag", 32'(det_flag), 32'(e_det));
    endtask

    bit last_par = 0;

    // one cycle: kind 0 none, 1 addr, 2 data; flip injects a parity error on the previous phase
    task automatic cycle(input int kind, input bit tgt, input bit flip, input bit drv);
        @(negedge clk);
        compare_all();
        par_in    = last_par ^ flip;
        ad        = $urandom;
        cbe_n     = 4'($urandom);
        addr_vld  = (kind == 1);
        data_vld  = (kind == 2);
        as_target = tgt;
        drive_en  = drv;
        last_par  = xor36(ad, cbe_n);
    endtask

    task automatic set_cmd(input logic [15:0] v);
        @(negedge clk);
        compare_all();
        cmd_we = 1; cmd_wdata = v;
        @(negedge clk);
        compare_all();
        cmd_we = 0;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R8: reset state
        vectors++;
        cmp("R8 perr_n", 32'(perr_n), 1);
        cmp("R8 serr_n", 32'(serr_n), 1);
        cmp("R8 det_flag", 32'(det_flag), 0);
        cmp("R8 par_oe", 32'(par_oe), 0);
        cmp("R1 reset enables", 32'(cmd_rdata), 0);
        // R1: all-ones write keeps only the two enables
        set_cmd(16'hFFFF);
        @(negedge clk);
        vectors++;
        cmp("R1 only enables stored", 32'(cmd_rdata), 32'h0140);
        set_cmd(16'hFEBF);
        set_cmd(16'h0000);
        // R7: mismatch with all enables off sets only the flag; R4 perr silent
        cycle(2, 0, 0, 1);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);
        det_clr = 1; cycle(0, 0, 0, 0); det_clr = 0;
        // R4 master data error with response on
        set_cmd(16'h0040);
        cycle(2, 0, 0, 0);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 0);
        // R5 address error with response only: no serr
        cycle(1, 1, 0, 0);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 0);
        set_cmd(16'h0140);
        cycle(1, 1, 0, 0);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 0);
        // R6 target data error, wdpe off then on
        cycle(2, 1, 0, 0);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 0);
        wdpe_en = 1;
        cycle(2, 1, 0, 0);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 0);
        // R7 clear and mismatch at the same edge: set wins
        cycle(2, 0, 0, 0);
        det_clr = 1; cycle(0, 0, 1, 0); det_clr = 0;
        cycle(0, 0, 0, 0);
        // random back-to-back traffic with shifting enables
        for (int n = 0; n < 4000; n++) begin
            if (n % 97 == 0) set_cmd(16'($urandom));
            wdpe_en = 1'($urandom);
            det_clr = ($urandom % 8) == 0;
            if (n == 2500) begin
                // R8 reset drops a pending phase
                @(negedge clk); compare_all(); rst = 1;
                @(negedge clk); compare_all(); rst = 0;
            end
            cycle($urandom % 3, 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
        end
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end
endmodule